// File: doc/BRIEF.md
# Mixed-Sign Saturating Accumulate Unit

This unit adds a vector of addend lanes into a vector of accumulator lanes where the two operands are read with opposite signedness. With the mode bit low the accumulator is signed, the addend is read as unsigned, and each result is clamped to the signed range of the lane. With the mode bit high the accumulator is unsigned, the addend is read as two's complement, and each result is clamped to the unsigned range of the lane. Lane width is chosen per operation from 8, 16, 32 or 64 bits.

A scalar select keeps only the lowest lane and zeroes the rest. A width select chooses between a full 128-bit vector and a 64-bit vector whose upper half is zeroed. Lanes that are zeroed by either select never contribute to saturation. Any saturating operation raises a sticky flag in a 32-bit status word, which stays set until reset. A result is registered and appears one clock after the operation is accepted.

Top module: `mixsat_accum`

## Requirements
- R1: After synchronous reset, `accum_out`, `sat_hit`, `res_valid` and `status_word` are all zero.
- R2: With `mode_sel` = 0, each addend lane is read unsigned and each accumulator lane signed; the exact sum is returned when it fits the signed lane range, and the result never clamps to the signed minimum (e.g. byte addend 0xFF plus accumulator 0x80 gives 0x7F with no saturation).
- R3: With `mode_sel` = 0, a sum above the signed maximum returns the signed maximum (0x7F.., top bit clear, rest set) and saturates; this includes any addend above the signed maximum with a non-negative accumulator.
- R4: With `mode_sel` = 1, a negative addend whose sum with the accumulator is below zero returns zero and saturates.
- R5: With `mode_sel` = 1, a non-negative addend whose sum carries out of the lane returns all ones and saturates.
- R6: With `mode_sel` = 1, a negative addend added to an accumulator above the signed maximum never saturates and returns the exact lane sum.
- R7: `size_code` 0, 1, 2, 3 selects 8, 16, 32, 64-bit lanes, lane k occupying bits [k*W +: W]; every lane is computed independently.
- R8: With `scalar_sel` = 1 only lane 0 is computed, all higher bits of `accum_out` are zero, and saturation in other lanes is ignored.
- R9: With `wide_sel` = 0 (64-bit vector) bits 127:64 of `accum_out` are zero and saturation in those lanes is ignored; `wide_sel` = 1 processes all 128 bits.
- R10: `sat_hit` is 1 when the last accepted operation saturated in an active lane; bit 27 of `status_word` is a sticky copy that stays set until reset, all other status bits are zero.
- R11: `res_valid` is high for exactly the cycle after an accepted operation (`op_valid` = 1); without `op_valid` the inputs have no effect and `accum_out`, `sat_hit` hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Accept an operation this cycle |
| mode_sel | input | 1 | 0: signed accumulator, unsigned addend; 1: unsigned accumulator, signed addend |
| size_code | input | 2 | Lane width: 0=8, 1=16, 2=32, 3=64 bits |
| scalar_sel | input | 1 | Compute lane 0 only |
| wide_sel | input | 1 | 1: 128-bit vector; 0: 64-bit vector |
| addend_vec | input | 128 | Addend lanes |
| accum_vec | input | 128 | Accumulator lanes |
| res_valid | output | 1 | Result registered from the previous cycle's operation |
| accum_out | output | 128 | New accumulator lanes |
| sat_hit | output | 1 | Last operation saturated |
| status_word | output | 32 | Status word, bit 27 is the sticky saturation flag |

## Verification
Every result (`accum_out`, `sat_hit`, `res_valid`) and the sticky bit of `status_word` are due one rising edge after the cycle in which `op_valid` is high. The bench drives each operation on a falling edge, drops `op_valid` at the next falling edge, and compares all outputs there, so exactly one rising edge separates stimulus from sample. Idle cycles are checked two falling edges later to confirm nothing moved, and the sticky flag is read again after later non-saturating operations.

// File: rtl/mixsat_pkg.sv
package mixsat_pkg;

    localparam int VEC_BITS    = 128;
    localparam int BASE_LANE   = 8;
    localparam int NUM_SIZES   = 4;
    localparam int STATUS_BITS = 32;
    localparam int STICKY_POS  = 27;

    typedef enum logic {
        ACC_SIGNED   = 1'b0,
        ACC_UNSIGNED = 1'b1
    } acc_mode_e;

    typedef enum logic [1:0] {
        LANE_8  = 2'd0,
        LANE_16 = 2'd1,
        LANE_32 = 2'd2,
        LANE_64 = 2'd3
    } lane_size_e;

    typedef struct packed {
        logic [VEC_BITS-1:0] value;
        logic                sat;
    } lane_result_t;

    function automatic logic [STATUS_BITS-1:0] make_status(input logic sticky);
        logic [STATUS_BITS-1:0] w;
        w = '0;
        w[STICKY_POS] = sticky;
        return w;
    endfunction

endpackage

// File: rtl/mixsat_lane.sv
module mixsat_lane
    import mixsat_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] addend,
    input  logic [W-1:0] acc,
    input  acc_mode_e    mode,
    output logic [W-1:0] res,
    output logic         sat
);
    // W+2 bits hold unsigned W-bit plus signed W-bit without loss.
    localparam int SW = W + 2;

    logic signed [SW-1:0] a_ext;
    logic signed [SW-1:0] c_ext;
    logic signed [SW-1:0] sum;
    logic signed [SW-1:0] hi_bound;
    logic signed [SW-1:0] lo_bound;
    logic        [W-1:0]  hi_w;
    logic        [W-1:0]  lo_w;

    always_comb begin
        if (mode == ACC_SIGNED) begin
            a_ext    = {2'b00, addend};
            c_ext    = {{2{acc[W-1]}}, acc};
            hi_bound = {3'b000, {(W-1){1'b1}}};
            lo_bound = {3'b111, {(W-1){1'b0}}};
            hi_w     = {1'b0, {(W-1){1'b1}}};
            lo_w     = {1'b1, {(W-1){1'b0}}};
        end else begin
            a_ext    = {{2{addend[W-1]}}, addend};
            c_ext    = {2'b00, acc};
            hi_bound = {2'b00, {W{1'b1}}};
            lo_bound = '0;
            hi_w     = {W{1'b1}};
            lo_w     = '0;
        end
        sum = a_ext + c_ext;
        if (sum > hi_bound) begin
            res = hi_w;
            sat = 1'b1;
        end else if (sum < lo_bound) begin
            res = lo_w;
            sat = 1'b1;
        end else begin
            res = sum[W-1:0];
            sat = 1'b0;
        end
    end

endmodule

// File: rtl/mixsat_row.sv
module mixsat_row
    import mixsat_pkg::*;
#(
    parameter int W   = 8,
    parameter int VEC = 128
) (
    input  logic [VEC-1:0] addend,
    input  logic [VEC-1:0] acc,
    input  acc_mode_e      mode,
    input  logic           scalar_sel,
    input  logic           wide_sel,
    output logic [VEC-1:0] res,
    output logic           any_sat
);
    localparam int N      = VEC / W;
    localparam int HALF_N = N / 2;

    logic [N-1:0] lane_sat;
    logic [N-1:0] lane_on;

    for (genvar i = 0; i < N; i++) begin : g_lane
        logic [W-1:0] raw;

        mixsat_lane #(.W(W)) u_lane (
            .addend (addend[i*W +: W]),
            .acc    (acc[i*W +: W]),
            .mode   (mode),
            .res    (raw),
            .sat    (lane_sat[i])
        );

        assign lane_on[i]      = scalar_sel ? (i == 0) : (wide_sel || (i < HALF_N));
        assign res[i*W +: W]   = lane_on[i] ? raw : '0;
    end

    assign any_sat = |(lane_sat & lane_on);

endmodule

// File: rtl/mixsat_accum.sv
module mixsat_accum
    import mixsat_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   op_valid,
    input  logic                   mode_sel,
    input  logic [1:0]             size_code,
    input  logic                   scalar_sel,
    input  logic                   wide_sel,
    input  logic [VEC_BITS-1:0]    addend_vec,
    input  logic [VEC_BITS-1:0]    accum_vec,
    output logic                   res_valid,
    output logic [VEC_BITS-1:0]    accum_out,
    output logic                   sat_hit,
    output logic [STATUS_BITS-1:0] status_word
);
    localparam int HALF = VEC_BITS / 2;

    logic [VEC_BITS-1:0] row_res [NUM_SIZES];
    logic [NUM_SIZES-1:0] row_sat;
    acc_mode_e            mode;
    lane_result_t         chosen;
    logic                 sticky;

    assign mode = acc_mode_e'(mode_sel);

    for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
        mixsat_row #(.W(BASE_LANE << g), .VEC(VEC_BITS)) u_row (
            .addend     (addend_vec),
            .acc        (accum_vec),
            .mode       (mode),
            .scalar_sel (scalar_sel),
            .wide_sel   (wide_sel),
            .res        (row_res[g]),
            .any_sat    (row_sat[g])
        );
    end

    always_comb begin
        chosen.value = row_res[size_code];
        chosen.sat   = row_sat[size_code];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            accum_out <= '0;
            sat_hit   <= 1'b0;
            sticky    <= 1'b0;
        end else begin
            res_valid <= op_valid;
            if (op_valid) begin
                accum_out <= chosen.value;
                sat_hit   <= chosen.sat;
                sticky    <= sticky | chosen.sat;
            end
        end
    end

    assign status_word = make_status(sticky);

    // R10: the sticky flag never drops without reset
    assert_sticky_hold_R10: assert property (@(posedge clk) disable iff (rst)
        status_word[STICKY_POS] |=> status_word[STICKY_POS]);

    // R10: a saturating result is always reflected in the status word
    assert_sat_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        sat_hit |-> status_word[STICKY_POS]);

    // R11: a result follows every accepted operation
    assert_valid_latency_R11: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> res_valid);

    // R11: idle cycles leave the result untouched
    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> (!res_valid && $stable(accum_out) && $stable(sat_hit)));

    // R9: the 64-bit vector form leaves the upper half zero
    assert_narrow_upper_R9: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !wide_sel) |=> (accum_out[VEC_BITS-1:HALF] == '0));

    // R8: the scalar form leaves the upper half zero
    assert_scalar_upper_R8: assert property (@(posedge clk) disable iff (rst)
        (op_valid && scalar_sel) |=> (accum_out[VEC_BITS-1:HALF] == '0));

endmodule

// File: tb/mixsat_accum_test.sv
module mixsat_accum_test;

    typedef struct packed {
        int unsigned req;
        logic        mode;
        logic [1:0]  size;
        logic        scal;
        logic        wide;
        logic [63:0] a;
        logic [63:0] c;
        logic [63:0] e;
        logic        esat;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t TBL [NV] = '{
        // R3 bytes: 0x80+0, 1+0x7F, 0xFF+1, 0xF0+0x10 clamp to 0x7F
        '{3, 1'b0, 2'd0, 1'b0, 1'b1, 64'h8001FF10007F05F0, 64'h007F01F08000FF10, 64'h7F7F7F00807F047F, 1'b1},
        // R2 bytes, 64-bit vector form: 0xFF+0x80 gives 0x7F exact
        '{2, 1'b0, 2'd0, 1'b0, 1'b0, 64'h01020304050607FF, 64'hFFFEFDFC00000080, 64'h000000000506077F, 1'b0},
        // R4 R5 R6 bytes in unsigned-accumulator mode
        '{4, 1'b1, 2'd0, 1'b0, 1'b1, 64'h80FF7F01F0FF0090, 64'h1000FFFF05C8ABF0, 64'h0000FFFF00C7AB80, 1'b1},
        // R6 halfwords, no saturation
        '{6, 1'b1, 2'd1, 1'b0, 1'b1, 64'hFFFF000180007FFF, 64'h8000FFFE80000001, 64'h7FFFFFFF00008000, 1'b0},
        // R3 halfwords
        '{3, 1'b0, 2'd1, 1'b0, 1'b1, 64'hFFFF800000011234, 64'h000080007FFFEDCC, 64'h7FFF00007FFF0000, 1'b1},
        // R2 words, exact top value
        '{2, 1'b0, 2'd2, 1'b0, 1'b1, 64'hFFFFFFFF00000010, 64'h80000000FFFFFFF0, 64'h7FFFFFFF00000000, 1'b0},
        // R5 words: below zero and carry out
        '{5, 1'b1, 2'd2, 1'b0, 1'b1, 64'h8000000000000002, 64'h7FFFFFFFFFFFFFFE, 64'h00000000FFFFFFFF, 1'b1},
        // R3 doubleword: unsigned addend above signed max, acc zero
        '{3, 1'b0, 2'd3, 1'b0, 1'b1, 64'h8000000000000000, 64'h0000000000000000, 64'h7FFFFFFFFFFFFFFF, 1'b1},
        // R2 doubleword exact maximum
        '{2, 1'b0, 2'd3, 1'b0, 1'b1, 64'hFFFFFFFFFFFFFFFF, 64'h8000000000000000, 64'h7FFFFFFFFFFFFFFF, 1'b0},
        // R7 doubleword small sum with negative acc
        '{7, 1'b0, 2'd3, 1'b0, 1'b1, 64'h0000000000000005, 64'hFFFFFFFFFFFFFFFD, 64'h0000000000000002, 1'b0},
        // R3 doubleword: negative acc still overflows
        '{3, 1'b0, 2'd3, 1'b0, 1'b1, 64'h8000000000000001, 64'hFFFFFFFFFFFFFFFF, 64'h7FFFFFFFFFFFFFFF, 1'b1},
        // R4 doubleword below zero
        '{4, 1'b1, 2'd3, 1'b0, 1'b1, 64'hFFFFFFFFFFFFFFFF, 64'h0000000000000000, 64'h0000000000000000, 1'b1},
        // R5 doubleword carry out
        '{5, 1'b1, 2'd3, 1'b0, 1'b1, 64'h0000000000000001, 64'hFFFFFFFFFFFFFFFF, 64'hFFFFFFFFFFFFFFFF, 1'b1},
        // R6 doubleword: most negative addend onto 2^63
        '{6, 1'b1, 2'd3, 1'b0, 1'b1, 64'h8000000000000000, 64'h8000000000000000, 64'h0000000000000000, 1'b0},
        // R6 doubleword: -1 onto all ones
        '{6, 1'b1, 2'd3, 1'b0, 1'b1, 64'hFFFFFFFFFFFFFFFF, 64'hFFFFFFFFFFFFFFFF, 64'hFFFFFFFFFFFFFFFE, 1'b0},
        // R8 scalar bytes: other lanes would saturate but are ignored
        '{8, 1'b0, 2'd0, 1'b1, 1'b1, 64'h8080808080808005, 64'h0000000000000003, 64'h0000000000000008, 1'b0},
        // R8 scalar halfword saturating to zero in lane 0
        '{8, 1'b1, 2'd1, 1'b1, 1'b1, 64'h000100010001FFFF, 64'hFFFFFFFFFFFF0000, 64'h0000000000000000, 1'b1}
    };

    logic         clk = 1'b0;
    logic         rst;
    logic         op_valid;
    logic         mode_sel;
    logic [1:0]   size_code;
    logic         scalar_sel;
    logic         wide_sel;
    logic [127:0] addend_vec;
    logic [127:0] accum_vec;
    logic         res_valid;
    logic [127:0] accum_out;
    logic         sat_hit;
    logic [31:0]  status_word;

    int tests  = 0;
    int failed = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    mixsat_accum uut (
        .clk         (clk),
        .rst         (rst),
        .op_valid    (op_valid),
        .mode_sel    (mode_sel),
        .size_code   (size_code),
        .scalar_sel  (scalar_sel),
        .wide_sel    (wide_sel),
        .addend_vec  (addend_vec),
        .accum_vec   (accum_vec),
        .res_valid   (res_valid),
        .accum_out   (accum_out),
        .sat_hit     (sat_hit),
        .status_word (status_word)
    );

    task automatic check(input string tag, input logic [129:0] act, input logic [129:0] exp);
        tests++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic run_op(input logic m, input logic [1:0] s, input logic sc, input logic w,
                          input logic [127:0] a, input logic [127:0] c);
        @(negedge clk);
        op_valid   = 1'b1;
        mode_sel   = m;
        size_code  = s;
        scalar_sel = sc;
        wide_sel   = w;
        addend_vec = a;
        accum_vec  = c;
        @(negedge clk);
        op_valid   = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failed++;
            tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, failed);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; op_valid = 1'b0; mode_sel = 1'b0; size_code = 2'd0;
        scalar_sel = 1'b0; wide_sel = 1'b1; addend_vec = '0; accum_vec = '0;
        do_reset();

        // R1 reset state
        check("R1 reset outputs", {res_valid, sat_hit, accum_out}, {2'b00, 128'h0});
        check("R1 reset status", {98'h0, status_word}, {98'h0, 32'h0});

        // R10 non-saturating op leaves sticky clear; R11 valid one cycle later
        run_op(1'b0, 2'd0, 1'b0, 1'b1, {16{8'h01}}, {16{8'h02}});
        check("R11 valid after op", {res_valid, sat_hit, accum_out}, {2'b10, {16{8'h03}}});
        check("R10 sticky clear", {98'h0, status_word}, {98'h0, 32'h0});

        // R7 table walk
        for (int i = 0; i < NV; i++) begin
            logic [127:0] exp_v;
            string tag;
            exp_v = (TBL[i].scal || !TBL[i].wide) ? {64'h0, TBL[i].e} : {TBL[i].e, TBL[i].e};
            run_op(TBL[i].mode, TBL[i].size, TBL[i].scal, TBL[i].wide,
                   {TBL[i].a, TBL[i].a}, {TBL[i].c, TBL[i].c});
            tag = $sformatf("R%0d vector %0d", TBL[i].req, i);
            check(tag, {res_valid, sat_hit, accum_out}, {1'b1, TBL[i].esat, exp_v});
        end

        // R10 sticky remains after non-saturating op
        run_op(1'b1, 2'd2, 1'b0, 1'b1, {4{32'h1}}, {4{32'h1}});
        check("R10 sat_hit clear", {res_valid, sat_hit, accum_out}, {2'b10, {4{32'h2}}});
        check("R10 sticky held", {98'h0, status_word}, {98'h0, 32'h0800_0000});

        // R9 upper half would saturate but is ignored in 64-bit form
        do_reset();
        run_op(1'b1, 2'd3, 1'b0, 1'b0, {64'h1, 64'h1}, {64'hFFFFFFFFFFFFFFFF, 64'h2});
        check("R9 upper ignored", {res_valid, sat_hit, accum_out}, {2'b10, 64'h0, 64'h3});
        check("R9 no sticky", {98'h0, status_word}, {98'h0, 32'h0});

        // R9 same operands with full width do saturate
        run_op(1'b1, 2'd3, 1'b0, 1'b1, {64'h1, 64'h1}, {64'hFFFFFFFFFFFFFFFF, 64'h2});
        check("R9 wide form", {res_valid, sat_hit, accum_out}, {2'b11, 64'hFFFFFFFFFFFFFFFF, 64'h3});

        // R11 inputs without op_valid have no effect
        @(negedge clk);
        mode_sel = 1'b0; size_code = 2'd0; addend_vec = {16{8'h55}}; accum_vec = {16{8'h11}};
        @(negedge clk);
        @(negedge clk);
        check("R11 idle hold", {res_valid, sat_hit, accum_out}, {2'b01, 64'hFFFFFFFFFFFFFFFF, 64'h3});

        // R1 reset clears the sticky flag
        do_reset();
        check("R1 reset clears sticky", {98'h0, status_word}, {98'h0, 32'h0});

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end

endmodule